// File: doc/BRIEF.md
# Pipelined Tree Barrier Synchronizer

This block is a global barrier for a group of processing elements (PEs) that advance together through bulk-synchronous stages. Each PE pulses its `arrive_i` bit when it reaches the barrier. The pulses are gathered by a binary tree of small registered aggregation nodes, one tree level per clock. Each node remembers which of its two children has arrived and forwards a single arrival to its parent once both have. When the top of the tree reports that every PE has arrived, a release travels back down the tree, one level per cycle. Every PE sees a single-cycle `release_o` pulse in the same cycle, and the shared stage counter steps forward in that cycle too.

Because every node is registered, the critical path does not depend on the PE count, and the barrier latency grows with log2 of that count. An arrival cannot be withdrawn once recorded. A PE that arrives again before its release has one extra arrival held for the following episode.

Top module: `tbar_sync`

## Requirements
- R1: While `rst_n` is low, and until the first barrier completes after reset, `release_o` is all zeros and `stage_o` is zero. Reset discards every recorded and pending arrival.
- R2: No `release_o` bit rises until every PE has an arrival recorded in the current episode.
- R3: All `release_o` bits rise together, for exactly one cycle. The pulse is visible 2·log2(NUM_PE)+2 clock edges after the edge that samples the last missing arrival, which is 10 edges for NUM_PE=16.
- R4: `stage_o` increases by one in the same cycle as the release pulse and holds its value in every other cycle.
- R5: Arrivals may come in any order and spread over any number of cycles. A recorded arrival stays in force until its release.
- R6: A second arrival from a PE that is still waiting for release is held pending and does not count toward the current episode. At the release edge, the pending arrival becomes that PE's arrival for the next episode.
- R7: Each PE holds at most one pending arrival. Further arrivals before the release are discarded.
- R8: If `arrive_i` is held high on every PE, a release pulse occurs every 2·log2(NUM_PE)+2 cycles.
- R9: `stage_o` wraps modulo 2^STAGE_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| arrive_i | input | NUM_PE | One arrival pulse bit per PE, sampled on the rising edge |
| release_o | output | NUM_PE | One release pulse bit per PE |
| stage_o | output | STAGE_W | Bulk-synchronous stage number shared by all PEs |

## Verification
The release is due a fixed 2·log2(NUM_PE)+2 edges after the last missing arrival is sampled. The bench counts that distance cycle by cycle from the sampling edge, with samples taken at the falling edge. It requires all zeros on `release_o` in every earlier cycle, all ones with the incremented stage in the due cycle, and zeros again one cycle later. For pending and repeated arrivals, the count starts at whichever edge the requirement names: the original arrival, the release edge that promotes a pending arrival, or the edge of the last fresh pulse. Quiet windows of several barrier latencies confirm that discarded or insufficient arrivals never produce a release.

// File: rtl/tbar_pkg.sv
package tbar_pkg;

  // Leaf progress within one barrier episode
  typedef enum logic [0:0] {
    LEAF_IDLE    = 1'b0,
    LEAF_WAITING = 1'b1
  } leaf_st_e;

  // Aggregation node progress within one barrier episode
  typedef enum logic [0:0] {
    NODE_COLLECT = 1'b0,
    NODE_SENT    = 1'b1
  } node_st_e;

  // Round-trip latency from the sampling edge of the last arrival to the release pulse
  function automatic int unsigned barrier_latency(input int unsigned num_pe);
    return 2 * $clog2(num_pe) + 2;
  endfunction

endpackage

// File: rtl/tbar_leaf.sv
module tbar_leaf
  import tbar_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arrive_i,
  input  logic rel_i,
  output logic up_o,
  output logic release_o
);

  leaf_st_e st_q, st_n;
  logic     pend_q, pend_n;
  logic     up_q, up_n;
  logic     rel_q, rel_n;

  always_comb begin
    st_n   = st_q;
    pend_n = pend_q;
    up_n   = 1'b0;
    rel_n  = rel_i;
    if (rel_i) begin
      // release edge: a held or simultaneous arrival opens the next episode
      if (pend_q || arrive_i) begin
        st_n = LEAF_WAITING;
        up_n = 1'b1;
      end else begin
        st_n = LEAF_IDLE;
      end
      pend_n = 1'b0;
    end else if (st_q == LEAF_IDLE) begin
      if (arrive_i) begin
        st_n = LEAF_WAITING;
        up_n = 1'b1;
      end
    end else if (arrive_i) begin
      pend_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LEAF_IDLE;
      pend_q <= 1'b0;
      up_q   <= 1'b0;
      rel_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      pend_q <= pend_n;
      up_q   <= up_n;
      rel_q  <= rel_n;
    end
  end

  assign up_o      = up_q;
  assign release_o = rel_q;

endmodule

// File: rtl/tbar_node.sv
module tbar_node
  import tbar_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic up_a_i,
  input  logic up_b_i,
  input  logic rel_i,
  output logic up_o,
  output logic rel_o
);

  node_st_e st_q, st_n;
  logic     seen_a_q, seen_a_n;
  logic     seen_b_q, seen_b_n;
  logic     up_q, up_n;
  logic     rel_q, rel_n;
  logic     flag_en;

  assign flag_en = up_a_i | up_b_i | rel_i;

  always_comb begin
    st_n     = st_q;
    seen_a_n = seen_a_q | up_a_i;
    seen_b_n = seen_b_q | up_b_i;
    up_n     = 1'b0;
    rel_n    = rel_i;
    if (rel_i) begin
      seen_a_n = 1'b0;
      seen_b_n = 1'b0;
      st_n     = NODE_COLLECT;
    end else if (st_q == NODE_COLLECT && seen_a_n && seen_b_n) begin
      up_n = 1'b1;
      st_n = NODE_SENT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= NODE_COLLECT;
      seen_a_q <= 1'b0;
      seen_b_q <= 1'b0;
      up_q     <= 1'b0;
      rel_q    <= 1'b0;
    end else begin
      st_q  <= st_n;
      up_q  <= up_n;
      rel_q <= rel_n;
      if (flag_en) begin
        seen_a_q <= seen_a_n;
        seen_b_q <= seen_b_n;
      end
    end
  end

  assign up_o  = up_q;
  assign rel_o = rel_q;

endmodule

// File: rtl/tbar_root.sv
module tbar_root #(
  parameter int unsigned STAGE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               all_up_i,
  input  logic               stage_step_i,
  output logic               rel_o,
  output logic [STAGE_W-1:0] stage_o
);

  logic               rel_q;
  logic [STAGE_W-1:0] stage_q, stage_n;

  always_comb begin
    stage_n = stage_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q   <= 1'b0;
      stage_q <= '0;
    end else begin
      rel_q <= all_up_i;
      if (stage_step_i) begin
        stage_q <= stage_n;
      end
    end
  end

  assign rel_o   = rel_q;
  assign stage_o = stage_q;

endmodule

// File: rtl/tbar_sync.sv
module tbar_sync #(
  parameter int unsigned NUM_PE  = 16,
  parameter int unsigned STAGE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_PE-1:0]  arrive_i,
  output logic [NUM_PE-1:0]  release_o,
  output logic [STAGE_W-1:0] stage_o
);

  localparam int unsigned HEAP_TOP = 2 * NUM_PE - 1;

  // reset: asserted asynchronously, removed on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_core_n = rst_sync_q[1];

  // heap numbering: node n has children 2n and 2n+1; leaves sit at NUM_PE..HEAP_TOP
  logic [HEAP_TOP:1]  up_v;
  logic [HEAP_TOP:1]  rel_v;
  logic [NUM_PE-1:1]  node_rel;

  for (genvar n = 1; n < NUM_PE; n++) begin : g_node
    tbar_node u_node (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .up_a_i (up_v[2*n]),
      .up_b_i (up_v[2*n+1]),
      .rel_i  (rel_v[n]),
      .up_o   (up_v[n]),
      .rel_o  (node_rel[n])
    );
    assign rel_v[2*n]   = node_rel[n];
    assign rel_v[2*n+1] = node_rel[n];
  end

  for (genvar j = 0; j < NUM_PE; j++) begin : g_leaf
    tbar_leaf u_leaf (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .arrive_i  (arrive_i[j]),
      .rel_i     (rel_v[NUM_PE+j]),
      .up_o      (up_v[NUM_PE+j]),
      .release_o (release_o[j])
    );
  end

  tbar_root #(
    .STAGE_W (STAGE_W)
  ) u_root (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .all_up_i     (up_v[1]),
    .stage_step_i (rel_v[NUM_PE]),
    .rel_o        (rel_v[1]),
    .stage_o      (stage_o)
  );

endmodule

// File: rtl/tbar_sync_chk.sv
module tbar_sync_chk #(
  parameter int unsigned NUM_PE  = 16,
  parameter int unsigned STAGE_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_PE-1:0]  arrive_i,
  input logic [NUM_PE-1:0]  release_o,
  input logic [STAGE_W-1:0] stage_o
);

  // saturating per-PE count of arrivals not yet consumed by a release
  logic [1:0]        owed_q [NUM_PE];
  logic [NUM_PE-1:0] owed_nz;

  for (genvar j = 0; j < NUM_PE; j++) begin : g_owed
    logic [1:0] after_rel;
    assign after_rel = (release_o[j] && owed_q[j] != 2'd0) ? owed_q[j] - 2'd1 : owed_q[j];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        owed_q[j] <= 2'd0;
      end else if (arrive_i[j] && after_rel != 2'd2) begin
        owed_q[j] <= after_rel + 2'd1;
      end else begin
        owed_q[j] <= after_rel;
      end
    end
    assign owed_nz[j] = (owed_q[j] != 2'd0);
  end

  // R2: a release only follows an arrival from every PE
  assert_release_needs_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|release_o) |-> (&owed_nz));

  // R3: all PEs released together
  assert_release_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (release_o == '0) || (&release_o));

  // R3: release lasts one cycle
  assert_release_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|release_o) |=> (release_o == '0));

  // R4: stage steps with each release
  assert_stage_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(release_o[0]) |-> (stage_o == STAGE_W'($past(stage_o) + 1'b1)));

  // R4: stage holds without a release
  assert_stage_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!release_o[0]) |-> $stable(stage_o));

endmodule

bind tbar_sync tbar_sync_chk #(
  .NUM_PE  (NUM_PE),
  .STAGE_W (STAGE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .arrive_i  (arrive_i),
  .release_o (release_o),
  .stage_o   (stage_o)
);

// File: tb/sim_tbar_sync.sv
`timescale 1ns/1ps
module sim_tbar_sync;

  localparam int unsigned N   = 16;
  localparam int unsigned SW  = 8;
  localparam int unsigned LAT = 2 * $clog2(N) + 2;

  // each entry: {first pulse mask, gap cycles}; the second pulse is the complement
  localparam logic [23:0] VEC [6] = '{
    {16'h0000, 8'd0},
    {16'h00FF, 8'd3},
    {16'hAAAA, 8'd0},
    {16'h7FFF, 8'd20},
    {16'h0001, 8'd5},
    {16'h5A3C, 8'd1}
  };

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  arrive;
  logic [N-1:0]  release_w;
  logic [SW-1:0] stage_w;

  int unsigned n_chk;
  int unsigned n_bad;
  logic [SW-1:0] exp_stage;
  bit done;

  tbar_sync #(.NUM_PE(N), .STAGE_W(SW)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .arrive_i  (arrive),
    .release_o (release_w),
    .stage_o   (stage_w)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // called at a falling edge; the mask is sampled on the next rising edge
  task automatic pulse(input logic [N-1:0] m);
    arrive = m;
    @(negedge clk);
    arrive = '0;
  endtask

  // no release for k cycles
  task automatic quiet(input int unsigned k, input string req);
    bit ok = 1'b1;
    logic [N-1:0] seen = '0;
    for (int unsigned c = 0; c < k; c++) begin
      @(negedge clk);
      if (release_w != '0) begin ok = 1'b0; seen = release_w; end
    end
    check(ok, req, 32'(seen), 32'h0);
  endtask

  // release expected k edges after the current falling edge's preceding sampling edge
  task automatic expect_release(input int unsigned k, input string req);
    quiet(k - 1, {req, " early"});
    @(negedge clk);
    exp_stage = exp_stage + 1'b1;
    check(release_w == {N{1'b1}}, {req, " release"}, 32'(release_w), 32'hFFFF);
    check(stage_w == exp_stage, {req, " R4 stage"}, 32'(stage_w), 32'(exp_stage));
    @(negedge clk);
    check(release_w == '0, {req, " R3 pulse end"}, 32'(release_w), 32'h0);
  endtask

  task automatic do_reset();
    arrive = '0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    check(release_w == '0, "R1 release in reset", 32'(release_w), 32'h0);
    check(stage_w == '0, "R1 stage in reset", 32'(stage_w), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_stage = '0;
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    exp_stage = '0;
    do_reset();

    // table of split arrivals: R2, R3, R5
    for (int v = 0; v < 6; v++) begin
      logic [N-1:0] first;
      int unsigned  gap;
      first = VEC[v][23:8];
      gap   = VEC[v][7:0];
      if (first != '0) begin
        pulse(first);
        quiet(gap + LAT, "R2 partial arrival");
      end
      pulse(~first);
      expect_release(LAT, "R3 R5 split arrival");
    end

    // R6: second arrival held for the next episode
    pulse({N{1'b1}});
    pulse(16'h0008);
    expect_release(LAT - 1, "R6 first episode");
    quiet(3 * LAT, "R6 pending alone");
    pulse(~16'h0008);
    expect_release(LAT, "R6 pending counted");

    // R7: only one pending arrival kept
    pulse({N{1'b1}});
    pulse(16'h0020);
    pulse(16'h0020);
    expect_release(LAT - 2, "R7 first episode");
    pulse(~16'h0020);
    expect_release(LAT, "R7 one pending");
    pulse(~16'h0020);
    quiet(3 * LAT, "R7 extra discarded");
    pulse(16'h0020);
    expect_release(LAT, "R7 late arrival");

    // R8 and R9: arrivals held high, stage wraps
    arrive = {N{1'b1}};
    expect_release(LAT + 1, "R8 held first");
    for (int r = 0; r < 260; r++) begin
      expect_release(LAT - 1, "R8 R9 held periodic");
    end
    check(stage_w == exp_stage, "R9 wrapped stage", 32'(stage_w), 32'(exp_stage));
    arrive = '0;
    expect_release(LAT - 1, "R8 drain recorded");
    expect_release(LAT - 1, "R6 drain pending");
    quiet(3 * LAT, "R8 idle after drain");

    // R1: reset mid-episode discards recorded arrivals
    pulse(16'h7FFF);
    pulse(16'h7FFF);
    do_reset();
    pulse(16'h7FFF);
    quiet(3 * LAT, "R1 arrivals cleared");
    pulse(16'h8000);
    expect_release(LAT, "R1 fresh episode");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule